// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit counting channel of an interval timer. A load strobe sets a new count and restarts the channel. Elapsed ticks then accumulate on every cycle where the tick enable is high and the channel is allowed to run. The channel shows two results: the live count, and one output pin whose waveform depends on the selected mode. Six modes are provided: a one-shot terminal flag, a gate-triggered one-shot, a rate generator, a square wave generator, and software- and gate-triggered strobes.

The gate input has a different meaning in each mode. In some modes its level pauses counting. In others its rising edge restarts the count from the loaded value. In the periodic modes a low gate also forces the output high. The mode input is a live configuration input. Mode codes 6 and 7 fold onto the rate and square wave modes.

Top module: `interval_channel`

## Requirements
- R1: From reset until the first load, count_o reads 0 and out_o is low when mode is 0 and high for every other mode code.
- R2: A load sets the count N to load_val, with load_val 0 standing for 65536. It clears the elapsed ticks, so in the next cycle count_o equals load_val. A tick or gate edge in the same cycle as a load is discarded.
- R3: In modes 0, 1, 4 and 5, count_o equals (N minus elapsed ticks) modulo 65536.
- R4: In modes 0 and 1, out_o is high exactly while elapsed ticks are at least N, and it stays high until the next load.
- R5: In mode 2, with elapsed ticks d, out_o is low only when d is a nonzero multiple of N, and count_o equals N minus (d mod N), taken modulo 65536.
- R6: In mode 3, out_o is high while (d mod N) is below (N+1)/2 and low otherwise, and count_o equals N minus ((2·d) mod N), taken modulo 65536.
- R7: In modes 4 and 5, out_o is low only while elapsed ticks equal N, so there is a single low strobe per load or restart.
- R8: In modes 1, 2, 3 and 5, a rising edge on gate (gate high, low in the previous cycle) clears the elapsed ticks.
- R9: In modes 0 and 4, ticks are counted only while gate is high. A gate edge has no other effect.
- R10: In modes 2 and 3, a low gate stops counting and holds out_o high.
- R11: Mode code 6 behaves exactly as mode 2, and mode code 7 exactly as mode 3.
- R12: Elapsed ticks advance only in cycles where tick_en is high. In modes 1 and 5 the gate level does not pause counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Counting tick enable, one tick per high cycle |
| gate | input | 1 | Gate: level enable or rising-edge trigger depending on mode |
| load | input | 1 | Load strobe for a new count |
| load_val | input | 16 | Count to load; 0 means 65536 |
| mode | input | 3 | Counting mode code, binary value n selects mode n |
| count_o | output | 16 | Live count |
| out_o | output | 1 | Mode-dependent output waveform |

## Verification
A tick and a restart can land in the same cycle. A restart comes from a load or from a gate rising edge. The bench provokes this by pulsing load while tick_en is high, and by raising gate on a ticking cycle in the periodic modes. In both cases the scoreboard expects the elapsed count to start from zero, with no tick applied. A cycle model that works from an unbounded elapsed value and modulo arithmetic judges every cycle's count and output independently of the counters used in the RTL.

// File: rtl/interval_pkg.sv
`timescale 1ns/1ps
package interval_pkg;

  typedef enum logic [2:0] {
    MODE_ONESHOT  = 3'd0,
    MODE_RETRIG   = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } tmode_e;

  // codes 6 and 7 alias the periodic modes
  function automatic tmode_e fold_mode(input logic [2:0] raw);
    case (raw)
      3'd6:    fold_mode = MODE_RATE;
      3'd7:    fold_mode = MODE_SQUARE;
      default: fold_mode = tmode_e'(raw);
    endcase
  endfunction

  function automatic logic gate_restarts(input tmode_e m);
    return (m == MODE_RETRIG) || (m == MODE_RATE) ||
           (m == MODE_SQUARE) || (m == MODE_HWSTROBE);
  endfunction

  function automatic logic gate_enables(input tmode_e m);
    return (m != MODE_RETRIG) && (m != MODE_HWSTROBE);
  endfunction

endpackage

// File: rtl/interval_gate_ctl.sv
`timescale 1ns/1ps
module interval_gate_ctl
  import interval_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_en,
  input  logic   gate,
  input  logic   load,
  input  tmode_e mode,
  output logic   adv,
  output logic   clr,
  output logic   loaded
);

  logic gate_q;
  logic loaded_d;
  logic rise;
  logic run;

  always_comb begin
    rise     = gate & ~gate_q;
    clr      = load | (rise & gate_restarts(mode));
    run      = loaded & (gate | ~gate_enables(mode));
    adv      = tick_en & run & ~clr;
    loaded_d = loaded | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      loaded <= 1'b0;
    end else begin
      gate_q <= gate;
      loaded <= loaded_d;
    end
  end

endmodule

// File: rtl/interval_elapsed.sv
`timescale 1ns/1ps
module interval_elapsed #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          clr,
  input  logic          adv,
  output logic [CW:0]   reload,
  output logic [CW:0]   el,
  output logic [CW-1:0] el_lo,
  output logic [CW-1:0] ph,
  output logic [CW-1:0] ph2
);

  localparam int            XW   = CW + 1;
  localparam logic [XW-1:0] FULL = XW'(1) << CW;
  localparam logic [XW-1:0] SAT  = '1;

  logic [XW-1:0] reload_d, el_d, ph_inc, step2;
  logic [CW-1:0] el_lo_d, ph_d, ph2_d;

  always_comb begin
    reload_d = reload;
    el_d     = el;
    el_lo_d  = el_lo;
    ph_d     = ph;
    ph2_d    = ph2;
    ph_inc   = {1'b0, ph} + XW'(1);
    step2    = {1'b0, ph2} + XW'(2);
    if (load) begin
      reload_d = (load_val == '0) ? FULL : {1'b0, load_val};
    end
    if (clr) begin
      el_d    = '0;
      el_lo_d = '0;
      ph_d    = '0;
      ph2_d   = '0;
    end else if (adv) begin
      el_d    = (el == SAT) ? el : el + XW'(1);
      el_lo_d = el_lo + CW'(1);
      ph_d    = (ph_inc == reload) ? '0 : ph_inc[CW-1:0];
      if (reload == XW'(1)) begin
        ph2_d = '0;
      end else if (step2 >= reload) begin
        ph2_d = CW'(step2 - reload);
      end else begin
        ph2_d = step2[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= FULL;
      el     <= '0;
      el_lo  <= '0;
      ph     <= '0;
      ph2    <= '0;
    end else begin
      reload <= reload_d;
      el     <= el_d;
      el_lo  <= el_lo_d;
      ph     <= ph_d;
      ph2    <= ph2_d;
    end
  end

endmodule

// File: rtl/interval_outgen.sv
`timescale 1ns/1ps
module interval_outgen
  import interval_pkg::*;
#(
  parameter int CW = 16
) (
  input  tmode_e        mode,
  input  logic          gate,
  input  logic          loaded,
  input  logic [CW:0]   reload,
  input  logic [CW:0]   el,
  input  logic [CW-1:0] el_lo,
  input  logic [CW-1:0] ph,
  input  logic [CW-1:0] ph2,
  output logic          out_o,
  output logic [CW-1:0] count_o
);

  localparam int XW = CW + 1;

  logic [XW-1:0] half;

  always_comb begin
    half = (reload + XW'(1)) >> 1;
    if (!loaded) begin
      out_o   = (mode != MODE_ONESHOT);
      count_o = '0;
    end else begin
      case (mode)
        MODE_ONESHOT, MODE_RETRIG: begin
          out_o   = (el >= reload);
          count_o = reload[CW-1:0] - el_lo;
        end
        MODE_RATE: begin
          out_o   = ~gate | ~((ph == '0) && (el != '0));
          count_o = reload[CW-1:0] - ph;
        end
        MODE_SQUARE: begin
          out_o   = ~gate | ({1'b0, ph} < half);
          count_o = reload[CW-1:0] - ph2;
        end
        default: begin
          out_o   = (el != reload);
          count_o = reload[CW-1:0] - el_lo;
        end
      endcase
    end
  end

endmodule

// File: rtl/interval_channel.sv
`timescale 1ns/1ps
module interval_channel
  import interval_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [2:0]    mode,
  output logic [CW-1:0] count_o,
  output logic          out_o
);

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  tmode_e        mode_e;
  logic          adv, clr, loaded;
  logic [CW:0]   reload, el;
  logic [CW-1:0] el_lo, ph, ph2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign mode_e = fold_mode(mode);

  interval_gate_ctl u_gate (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_en (tick_en),
    .gate    (gate),
    .load    (load),
    .mode    (mode_e),
    .adv     (adv),
    .clr     (clr),
    .loaded  (loaded)
  );

  interval_elapsed #(.CW(CW)) u_elapsed (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .load_val (load_val),
    .clr      (clr),
    .adv      (adv),
    .reload   (reload),
    .el       (el),
    .el_lo    (el_lo),
    .ph       (ph),
    .ph2      (ph2)
  );

  interval_outgen #(.CW(CW)) u_out (
    .mode    (mode_e),
    .gate    (gate),
    .loaded  (loaded),
    .reload  (reload),
    .el      (el),
    .el_lo   (el_lo),
    .ph      (ph),
    .ph2     (ph2),
    .out_o   (out_o),
    .count_o (count_o)
  );

endmodule

// File: rtl/interval_channel_chk.sv
`timescale 1ns/1ps
module interval_channel_chk
  import interval_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          gate,
  input logic          load,
  input logic [CW-1:0] load_val,
  input logic [2:0]    mode,
  input logic [CW-1:0] count_o,
  input logic          out_o
);

  // R2
  load_shows_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_o == $past(load_val)));

  // R4
  oneshot_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_mode(mode) == MODE_ONESHOT && out_o && !load)
    |=> (out_o || fold_mode(mode) != MODE_ONESHOT));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_mode(mode) == MODE_SWSTROBE && !out_o && tick_en && gate && !load)
    |=> (out_o || fold_mode(mode) != MODE_SWSTROBE));

  // R10
  periodic_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fold_mode(mode) == MODE_RATE || fold_mode(mode) == MODE_SQUARE) && !gate)
    |-> out_o);

  // R12
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load && !(gate && !$past(gate)))
    |=> ($stable(count_o) || !$stable(mode)));

endmodule

bind interval_channel interval_channel_chk #(.CW(CW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .gate     (gate),
  .load     (load),
  .load_val (load_val),
  .mode     (mode),
  .count_o  (count_o),
  .out_o    (out_o)
);

// File: tb/test_interval_channel.sv
`timescale 1ns/1ps
module test_interval_channel;

  logic        clk = 1'b0;
  logic        rst_n, tick_en, gate, load;
  logic [15:0] load_val;
  logic [2:0]  mode;
  logic [15:0] count_o;
  logic        out_o;

  always #2 clk = ~clk;

  interval_channel i_interval_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate), .load(load),
    .load_val(load_val), .mode(mode), .count_o(count_o), .out_o(out_o)
  );

  typedef struct {
    bit          eo;
    logic [15:0] ec;
    string       tag;
  } item_t;

  item_t sb[$];
  int    n_run = 0, n_fail = 0;
  int    m_d = 0, m_c = 65536;
  bit    m_ld = 0, m_gp = 0;
  logic [2:0] cur_mode = 3'd0;

  function automatic int fold(input int r);
    return (r == 6) ? 2 : (r == 7) ? 3 : r;
  endfunction

  function automatic bit exp_out(input int mm, input bit g);
    if (!m_ld) return (mm != 0);
    case (mm)
      0, 1:    return (m_d >= m_c);
      2:       return !g || !((m_d % m_c == 0) && m_d != 0);
      3:       return !g || ((m_d % m_c) < (m_c + 1) / 2);
      default: return (m_d != m_c);
    endcase
  endfunction

  function automatic int exp_cnt(input int mm);
    if (!m_ld) return 0;
    case (mm)
      2:       return (m_c - (m_d % m_c)) & 32'hFFFF;
      3:       return (m_c - ((2 * m_d) % m_c)) & 32'hFFFF;
      default: return (m_c - m_d) & 32'hFFFF;
    endcase
  endfunction

  task automatic check(input bit o, input logic [15:0] c, input bit eo,
                       input logic [15:0] ec, input string tag);
    n_run++;
    if (o !== eo || c !== ec) begin
      n_fail++;
      $display("FAIL %s: out=%0b count=%h expected out=%0b count=%h",
               tag, o, c, eo, ec);
    end
  endtask

  task automatic step(input bit g, input bit l, input int v, input bit tk,
                      input string tag);
    int  mm;
    bit  rise;
    bit  run;
    item_t it;
    @(negedge clk);
    gate = g; load = l; load_val = v[15:0]; tick_en = tk; mode = cur_mode;
    mm   = fold(int'(cur_mode));
    rise = g && !m_gp;
    m_gp = g;
    run  = (mm == 1 || mm == 5) ? 1'b1 : g;
    if (l) begin
      m_c  = (v[15:0] == 0) ? 65536 : int'(v[15:0]);
      m_d  = 0;
      m_ld = 1;
    end else if (rise && (mm == 1 || mm == 2 || mm == 3 || mm == 5)) begin
      m_d = 0;
    end else if (m_ld && tk && run) begin
      m_d++;
    end
    it.eo  = exp_out(mm, g);
    it.ec  = 16'(exp_cnt(mm));
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic run_n(input int n, input bit g, input bit tk, input string tag);
    for (int i = 0; i < n; i++) step(g, 1'b0, 0, tk, tag);
  endtask

  // monitor: compares one result per clock, just after the edge
  always @(posedge clk) begin
    item_t it;
    #1;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      check(out_o, count_o, it.eo, it.ec, it.tag);
    end
  end

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; gate = 1'b0; load = 1'b0;
    load_val = '0; mode = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state per mode
    mode = 3'd0; #1 check(out_o, count_o, 1'b0, 16'h0, "R1 mode0");
    mode = 3'd2; #1 check(out_o, count_o, 1'b1, 16'h0, "R1 mode2");
    mode = 3'd5; #1 check(out_o, count_o, 1'b1, 16'h0, "R1 mode5");
    mode = 3'd0;

    // R3 R4: one-shot flag, with R2 load and tick in the same cycle
    cur_mode = 3'd0;
    step(1, 1, 5, 1, "R2 load+tick");
    run_n(8, 1, 1, "R4 oneshot");
    // R9: gate low pauses counting in mode 0
    step(1, 1, 4, 0, "R2 reload");
    run_n(2, 1, 1, "R3 count");
    run_n(3, 0, 1, "R9 gate pause");
    run_n(4, 1, 1, "R9 resume");

    // R8: gate-triggered one-shot
    cur_mode = 3'd1;
    step(1, 1, 4, 1, "R2 load");
    run_n(3, 1, 1, "R12 mode1");
    run_n(2, 0, 1, "R12 gate low counts");
    run_n(4, 1, 1, "R8 retrigger");

    // R5: rate generator
    cur_mode = 3'd2;
    step(1, 1, 4, 0, "R2 load");
    run_n(12, 1, 1, "R5 rate");
    run_n(3, 0, 1, "R10 rate gate low");
    run_n(6, 1, 1, "R8 rate restart");
    step(1, 1, 1, 0, "R2 load one");
    run_n(3, 1, 1, "R5 count one");

    // R6: square wave, odd and even counts
    cur_mode = 3'd3;
    step(1, 1, 5, 0, "R2 load");
    run_n(12, 1, 1, "R6 odd");
    step(1, 1, 4, 0, "R2 load");
    run_n(10, 1, 1, "R6 even");
    run_n(3, 0, 1, "R10 square gate low");
    run_n(4, 1, 1, "R8 square restart");

    // R7: software strobe, gate pause
    cur_mode = 3'd4;
    step(1, 1, 3, 0, "R2 load");
    run_n(2, 1, 1, "R7 strobe");
    run_n(2, 0, 1, "R9 strobe pause");
    run_n(5, 1, 1, "R7 strobe once");

    // hardware strobe and gate restart
    cur_mode = 3'd5;
    step(1, 1, 3, 0, "R2 load");
    run_n(5, 1, 1, "R7 hw strobe");
    run_n(1, 0, 1, "R12 hw gate low");
    run_n(6, 1, 1, "R8 hw restart");

    // R11: alias codes
    cur_mode = 3'd6;
    step(1, 1, 3, 0, "R11 load");
    run_n(8, 1, 1, "R11 code6");
    cur_mode = 3'd7;
    step(1, 1, 5, 0, "R11 load");
    run_n(8, 1, 1, "R11 code7");

    // load of zero means 65536
    cur_mode = 3'd0;
    step(1, 1, 0, 0, "R2 zero");
    run_n(3, 1, 1, "R3 zero wrap");

    // R12: sparse ticks
    cur_mode = 3'd2;
    step(1, 1, 3, 0, "R2 load");
    for (int i = 0; i < 12; i++) step(1, 0, 0, i[0], "R12 sparse");

    // restart on gate rise coinciding with a tick
    step(0, 0, 0, 1, "R10 low");
    step(1, 0, 0, 1, "R8 rise+tick");
    run_n(3, 1, 1, "R8 after");

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule